// File: doc/BRIEF.md
# Sensor unlock UART transmitter

This block drives the serial input of a sensor that refuses command data until it has seen an unlock preamble. A single start pulse runs the whole exchange. The block sends the unlock word (0xD4 by default) a fixed number of times, ten by default, and holds the line idle for a timed interval after each copy. It then sends eight command bytes back to back. The command bytes are captured from the input vector when the start pulse is accepted.

Each character uses 8E2 framing: a start bit, eight data bits sent least significant bit first, an even parity bit and two stop bits. The bit period and the idle interval are derived from parameters for the clock frequency, the baud rate (115200 by default) and the gap length in microseconds (1000 by default). The design contains no hand-computed cycle counts. One sequencer state machine does all the ordering and loads and counts down its own gap timer. A separate character shifter and a baud counter produce the waveform on the line.

Top module: `sensor_unlock_tx`

## Requirements
- R1: After reset the serial line is high, busy is low and done is low. Whenever no character is being shifted out, the line stays high.
- R2: Every character is 12 bit periods long. Each bit period is CLK_HZ/BAUD clock cycles. The bits are: a 0 start bit, then data bits 0 to 7 in that order, then a parity bit equal to the XOR of the eight data bits (even parity), then two 1 stop bits.
- R3: After an accepted start, the first UNLOCK_REPEAT characters (10 by default) all carry UNLOCK_WORD (0xD4 by default).
- R4: After each unlock character, including the last one, the line stays high for at least GAP_CYC = CLK_HZ*GAP_US/1e6 cycles and at most GAP_CYC+4 cycles before the next start bit.
- R5: After the preamble, the CMD_COUNT (8) command bytes are sent in index order. Byte i is taken from bits [8i+7:8i] of cmd_bytes, so bits [7:0] go first. The idle time between command characters is shorter than one bit period.
- R6: The command bytes are captured in the cycle the start pulse is accepted. Later changes to cmd_bytes do not change the bytes sent in that run.
- R7: Busy rises in the cycle after the start pulse is accepted. It stays high until the last stop bit of the final command byte is complete, then falls. Done is high for exactly one cycle, in the cycle where busy falls.
- R8: A start pulse that arrives while busy is high is ignored. The run in progress is not restarted and no extra characters follow it. A start pulse given after done begins a new, complete run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the unlock and command sequence |
| cmd_bytes | input | CMD_COUNT*DATA_BITS | Command bytes; byte i is at bits [8i+7:8i] |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the last command character has finished |

## Verification
The bench decodes the line at the middle of each bit period. It checks every character's data, parity and stop bits, and measures the idle time before each start bit. A design that dropped the gap after the tenth unlock copy, or counted the gap one copy short, would show a short idle time at that point in the stream. A design with odd parity or with MSB-first data would fail on the command patterns, which include bytes with both even and odd numbers of ones. The bench also changes cmd_bytes and pulses start in the middle of a run. A design that read the command bytes live would send the changed bytes, and one that accepted the late start would restart the preamble or send extra characters. After the last character the bench checks the timing of busy and done: an early or late busy fall, or a done pulse longer than one cycle, is reported.

// File: rtl/sut_pkg.sv
package sut_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT,
    SQ_GAP
  } seq_state_t;
endpackage

// File: rtl/sut_baud_gen.sv
module sut_baud_gen #(
  parameter int DIV = 868
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(DIV - 1));

  assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DIV - 1));
endmodule

// File: rtl/sut_frame_tx.sv
module sut_frame_tx #(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 tx,
  output logic                 busy,
  output logic                 fdone
);
  localparam int FRAME_BITS = DATA_BITS + STOP_BITS + 2;
  localparam int SH_W       = FRAME_BITS - 1;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      bitcnt <= '0;
      tx     <= 1'b1;
      busy   <= 1'b0;
      fdone  <= 1'b0;
    end else begin
      fdone <= 1'b0;
      if (load && !busy) begin
        shreg  <= {{STOP_BITS{1'b1}}, ^data, data};
        bitcnt <= '0;
        tx     <= 1'b0;
        busy   <= 1'b1;
      end else if (busy && tick) begin
        if (bitcnt == CNT_W'(FRAME_BITS - 1)) begin
          busy  <= 1'b0;
          fdone <= 1'b1;
          tx    <= 1'b1;
        end else begin
          tx     <= shreg[0];
          shreg  <= {1'b1, shreg[SH_W-1:1]};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);
  assert_load_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitcnt < CNT_W'(FRAME_BITS)));
endmodule

// File: rtl/sut_sequencer.sv
module sut_sequencer
  import sut_pkg::*;
#(
  parameter int                   DATA_BITS     = 8,
  parameter int                   CMD_COUNT     = 8,
  parameter int                   UNLOCK_REPEAT = 10,
  parameter logic [DATA_BITS-1:0] UNLOCK_WORD   = 8'hD4,
  parameter int                   GAP_CYC       = 100000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [CMD_COUNT*DATA_BITS-1:0] cmd_flat,
  input  logic                           frame_busy,
  input  logic                           frame_done,
  output logic                           load,
  output logic [DATA_BITS-1:0]           load_data,
  output logic                           busy,
  output logic                           done
);
  localparam int REP_W = (UNLOCK_REPEAT > 1) ? $clog2(UNLOCK_REPEAT) : 1;
  localparam int IDX_W = (CMD_COUNT > 1) ? $clog2(CMD_COUNT) : 1;
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_t           state;
  logic                 phase_cmd;
  logic [REP_W-1:0]     rep;
  logic [IDX_W-1:0]     idx;
  logic [GAP_W-1:0]     timer;
  logic [DATA_BITS-1:0] cmd_mem [CMD_COUNT];

  wire accept = (state == SQ_IDLE) && start;

  for (genvar i = 0; i < CMD_COUNT; i++) begin : g_snap
    always_ff @(posedge clk) begin
      if (accept) cmd_mem[i] <= cmd_flat[i*DATA_BITS +: DATA_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      phase_cmd <= 1'b0;
      rep       <= '0;
      idx       <= '0;
      timer     <= '0;
      load      <= 1'b0;
      load_data <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            busy      <= 1'b1;
            phase_cmd <= 1'b0;
            rep       <= '0;
            idx       <= '0;
            state     <= SQ_LOAD;
          end
        end
        SQ_LOAD: begin
          load      <= 1'b1;
          load_data <= phase_cmd ? cmd_mem[idx] : UNLOCK_WORD;
          state     <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (frame_done) begin
            if (!phase_cmd) begin
              timer <= GAP_W'(GAP_CYC - 1);
              state <= SQ_GAP;
            end else if (idx == IDX_W'(CMD_COUNT - 1)) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= SQ_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_LOAD;
            end
          end
        end
        SQ_GAP: begin
          if (timer == '0) begin
            state <= SQ_LOAD;
            if (rep == REP_W'(UNLOCK_REPEAT - 1)) phase_cmd <= 1'b1;
            else rep <= rep + 1'b1;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_gap_line_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_GAP) |-> !frame_busy);
  assert_rep_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rep <= REP_W'(UNLOCK_REPEAT - 1));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done) |=> busy);
endmodule

// File: rtl/sensor_unlock_tx.sv
module sensor_unlock_tx #(
  parameter int                   CLK_HZ        = 100_000_000,
  parameter int                   BAUD          = 115_200,
  parameter int                   GAP_US        = 1000,
  parameter int                   DATA_BITS     = 8,
  parameter int                   STOP_BITS     = 2,
  parameter int                   CMD_COUNT     = 8,
  parameter int                   UNLOCK_REPEAT = 10,
  parameter logic [DATA_BITS-1:0] UNLOCK_WORD   = 8'hD4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [CMD_COUNT*DATA_BITS-1:0] cmd_bytes,
  output logic                           tx,
  output logic                           busy,
  output logic                           done
);
  localparam int    DIV     = CLK_HZ / BAUD;
  localparam longint GAP_L  = (longint'(CLK_HZ) * longint'(GAP_US)) / 64'd1_000_000;
  localparam int    GAP_CYC = (GAP_L < 1) ? 1 : int'(GAP_L);

  logic                 tick;
  logic                 f_busy;
  logic                 f_done;
  logic                 f_load;
  logic [DATA_BITS-1:0] f_data;

  sut_baud_gen #(.DIV(DIV)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (f_busy),
    .tick (tick)
  );

  sut_frame_tx #(.DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .load  (f_load),
    .data  (f_data),
    .tx    (tx),
    .busy  (f_busy),
    .fdone (f_done)
  );

  sut_sequencer #(
    .DATA_BITS    (DATA_BITS),
    .CMD_COUNT    (CMD_COUNT),
    .UNLOCK_REPEAT(UNLOCK_REPEAT),
    .UNLOCK_WORD  (UNLOCK_WORD),
    .GAP_CYC      (GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_flat  (cmd_bytes),
    .frame_busy(f_busy),
    .frame_done(f_done),
    .load      (f_load),
    .load_data (f_data),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: tb/sensor_unlock_tx_tb.sv
module sensor_unlock_tx_tb;
  localparam int CLK_HZ = 800_000;
  localparam int BAUD   = 100_000;
  localparam int GAPUS  = 50;
  localparam int BITP   = CLK_HZ / BAUD;
  localparam int GAPC   = CLK_HZ / 1_000_000 * GAPUS + (CLK_HZ % 1_000_000) * GAPUS / 1_000_000;
  localparam int NREP   = 10;
  localparam int NCMD   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] cmd_bytes = '0;
  logic        tx, busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sensor_unlock_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .GAP_US(GAPUS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_bytes(cmd_bytes),
    .tx(tx), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called at a negedge; counts idle-high cycles, then decodes one character.
  task automatic rx_frame(output logic [7:0] d, output logic pbit,
                          output bit fok, output int idle);
    idle = 0;
    while (tx !== 1'b0) begin
      idle++;
      @(negedge clk);
    end
    fok = 1'b1;
    repeat (BITP / 2) @(negedge clk);
    if (tx !== 1'b0) fok = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat (BITP) @(negedge clk);
      d[k] = tx;
    end
    repeat (BITP) @(negedge clk);
    pbit = tx;
    for (int s = 0; s < 2; s++) begin
      repeat (BITP) @(negedge clk);
      if (tx !== 1'b1) fok = 1'b0;
    end
    repeat (BITP - BITP / 2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx === 1'b1, "R1 line idle high", int'(tx), 1);
    chk(busy === 1'b0, "R1 busy low", int'(busy), 0);
    chk(done === 1'b0, "R1 done low", int'(done), 0);
    repeat (5) @(negedge clk);
    chk(tx === 1'b1, "R1 line stays high", int'(tx), 1);
  endtask

  task automatic t_sequence(input logic [63:0] cmds, input bit disturb);
    logic [7:0] d, exp;
    logic       pbit;
    bit         fok;
    int         idle;
    cmd_bytes = cmds;
    pulse_start();
    chk(busy === 1'b1, "R7 busy after start", int'(busy), 1);
    for (int f = 0; f < NREP + NCMD; f++) begin
      rx_frame(d, pbit, fok, idle);
      exp = (f < NREP) ? 8'hD4 : cmds[(f - NREP) * 8 +: 8];
      if (f < NREP) chk(d === exp, "R3 unlock byte", int'(d), int'(exp));
      else if (disturb) chk(d === exp, "R6 captured command byte", int'(d), int'(exp));
      else chk(d === exp, "R5 command byte order", int'(d), int'(exp));
      chk(pbit === ^exp, "R2 even parity bit", int'(pbit), int'(^exp));
      chk(fok, "R2 start and stop bits", int'(fok), 1);
      if (f >= 1 && f <= NREP)
        chk(idle >= GAPC && idle <= GAPC + 4, "R4 unlock gap length", idle, GAPC);
      else if (f > NREP)
        chk(idle < BITP, "R5 back to back commands", idle, 0);
      if (f < NREP + NCMD - 1)
        chk(busy === 1'b1, "R7 busy during run", int'(busy), 1);
      if (disturb && f == 2) begin
        cmd_bytes = ~cmds;
        pulse_start();
      end
    end
    chk(busy === 1'b1, "R7 busy through last stop bit", int'(busy), 1);
    @(negedge clk);
    chk(done === 1'b1, "R7 done pulse", int'(done), 1);
    chk(busy === 1'b0, "R7 busy falls with done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
    begin
      bit quiet = 1'b1;
      repeat (3 * BITP + GAPC) begin
        @(negedge clk);
        if (tx !== 1'b1 || busy !== 1'b0) quiet = 1'b0;
      end
      chk(quiet, "R8 no extra characters after run", int'(quiet), 1);
    end
    cmd_bytes = '0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence(64'h0123_4567_89AB_CDEF, 1'b0);
    t_sequence(64'hFF00_FF00_8001_7E81, 1'b1);
    t_sequence(64'h80FE_7F01_55AA_0003, 1'b0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule